// File: doc/BRIEF.md
# Three-Channel Audio DMA Register Bank

This block is the control and status register bank for a three-channel audio DMA controller: two playback channels (play A, play B) and one capture channel (record). It decodes a 256-byte window on a simple 32-bit register bus with single-cycle word accesses. The window holds a control word, a read-only status word, a 4-bit page register, a serial-control word and one sample-count register per channel. Each channel also has a frame address and a frame count register. These sit in a 16-byte sub-window whose meaning depends on the page register.

The DMA engines report the end of a block with one-cycle completion pulses. Each channel has an interrupt enable in the serial-control word. A completion on an enabled channel latches a pending flag. The status word and the single interrupt line show the OR of the three flags. Software clears a flag by writing serial control with that channel's enable bit moved from one to zero. All register values go out on ports so the DMA engines can use them.

Top module: `aud_regbank`

## Requirements
- R1: After reset, control reads 0x00000001, status reads 0x00000060, page reads 0 and serial control reads 0. All sample-count and frame registers read 0, and `irq_o` and `lo_clr_o` are low.
- R2: Read data is registered. `bus_rdata` shows the addressed value on the clock edge after the cycle in which `bus_rd` is high, and holds it until the next read.
- R3: A write to offset 0x0C keeps only `bus_wdata[3:0]` as the page. Reading 0x0C returns the page zero-extended.
- R4: Offsets 0x30 to 0x3F decode as the 12-bit address (page << 8) | offset. 0xC30, 0xC34, 0xC38 and 0xC3C are play A frame address, play A frame count, play B frame address and play B frame count. 0xD30 and 0xD34 are record frame address and record frame count. These six registers are full 32-bit read/write and appear on `fadr_o`/`fcnt_o` (channel n in bits 32n+31:32n).
- R5: Any offset that decodes to nothing reads as 0xFFFFFFFF, and writes to it change nothing. This covers 0xD38, 0xD3C, paged offsets on other pages, 0x10 and misaligned addresses.
- R6: The status word holds the play A pending flag in bit 2, play B in bit 1 and record in bit 0. Bits 6:5 read as 1. Bit 31 and `irq_o` both equal the OR of the three flags. Writes to status (0x04) are ignored.
- R7: A pulse on `chan_done[n]` sets channel n's pending flag only if that channel's enable was already set before the pulse cycle. The enables are serial-control bit 8 (play A), bit 9 (play B) and bit 10 (record).
- R8: A serial-control write that turns an enable from 1 to 0 clears that channel's pending flag, even if a completion pulse arrives in the same cycle. No other write clears a flag.
- R9: A write to a sample-count register (0x24 play A, 0x28 play B, 0x2C record) updates bits 15:0 only. Bits 31:16 keep their value.
- R10: A pulse on `chan_done[n]` copies bits 15:0 of channel n's sample-count register into its bits 31:16, whatever the enable.
- R11: A write to a frame-count register raises `lo_clr_o[n]` for exactly one cycle, in the same cycle the new count appears, to clear that channel's leftover byte offset.
- R12: Control (0x00) and serial control (0x20) are full 32-bit read/write and drive `ctrl_o` and `sctl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 8 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| chan_done | input | 3 | Completion pulses (bit 0 play A, bit 1 play B, bit 2 record) |
| ctrl_o | output | 32 | Control word |
| sctl_o | output | 32 | Serial-control word |
| scnt_o | output | 96 | Sample-count registers, channel n at bits 32n+31:32n |
| fadr_o | output | 96 | Frame address registers |
| fcnt_o | output | 96 | Frame count registers |
| lo_clr_o | output | 3 | One-cycle leftover-clear pulse per channel |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is a completion pulse in the same cycle as a serial-control write. Either the write drops an enable, which must win, or it raises an enable, which must not yet count. The bench reaches both by driving `chan_done` and the write strobe on the same falling edge. The full window is swept under every one of the sixteen pages, with a distinct pattern written to each offset. Every offset is then read back against a model built from the address map. The stimulus cycles the interrupt enables through all eight combinations and checks the status word and `irq_o` after each step.

// File: rtl/aud_reg_pkg.sv
package aud_reg_pkg;
  localparam int unsigned NCH     = 3;
  localparam int unsigned CH_W    = 2;
  localparam int unsigned DW      = 32;
  localparam int unsigned CW      = 16;
  localparam int unsigned AW      = 8;
  localparam int unsigned PW      = 4;
  localparam int unsigned XW      = AW + PW;
  localparam int unsigned EN_LSB  = 8;

  localparam logic [AW-1:0] PAGED_LO = 8'h30;
  localparam logic [AW-1:0] PAGED_HI = 8'h3F;

  localparam logic [XW-1:0] XA_CTRL  = 12'h000;
  localparam logic [XW-1:0] XA_STAT  = 12'h004;
  localparam logic [XW-1:0] XA_PAGE  = 12'h00C;
  localparam logic [XW-1:0] XA_SCTL  = 12'h020;
  localparam logic [XW-1:0] XA_SCNT0 = 12'h024;
  localparam logic [XW-1:0] XA_SCNT1 = 12'h028;
  localparam logic [XW-1:0] XA_SCNT2 = 12'h02C;
  localparam logic [XW-1:0] XA_FADR0 = 12'hC30;
  localparam logic [XW-1:0] XA_FCNT0 = 12'hC34;
  localparam logic [XW-1:0] XA_FADR1 = 12'hC38;
  localparam logic [XW-1:0] XA_FCNT1 = 12'hC3C;
  localparam logic [XW-1:0] XA_FADR2 = 12'hD30;
  localparam logic [XW-1:0] XA_FCNT2 = 12'hD34;

  localparam logic [DW-1:0] CTRL_RST   = 32'h0000_0001;
  localparam logic [DW-1:0] STAT_FIXED = 32'h0000_0060;

  typedef enum logic [2:0] {
    RS_NONE, RS_CTRL, RS_STAT, RS_PAGE, RS_SCTL, RS_SCNT, RS_FADR, RS_FCNT
  } rsel_e;

  typedef struct packed {
    rsel_e            kind;
    logic [CH_W-1:0]  ch;
  } rdec_t;
endpackage

// File: rtl/aud_addr_decode.sv
module aud_addr_decode
  import aud_reg_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] page,
  output rdec_t         dec
);
  logic [XW-1:0] ext;

  always_comb begin
    ext = {{PW{1'b0}}, addr};
    if (addr >= PAGED_LO && addr <= PAGED_HI) ext = {page, addr};
  end

  always_comb begin
    dec.kind = RS_NONE;
    dec.ch   = '0;
    case (ext)
      XA_CTRL:  dec.kind = RS_CTRL;
      XA_STAT:  dec.kind = RS_STAT;
      XA_PAGE:  dec.kind = RS_PAGE;
      XA_SCTL:  dec.kind = RS_SCTL;
      XA_SCNT0: begin dec.kind = RS_SCNT; dec.ch = 2'd0; end
      XA_SCNT1: begin dec.kind = RS_SCNT; dec.ch = 2'd1; end
      XA_SCNT2: begin dec.kind = RS_SCNT; dec.ch = 2'd2; end
      XA_FADR0: begin dec.kind = RS_FADR; dec.ch = 2'd0; end
      XA_FCNT0: begin dec.kind = RS_FCNT; dec.ch = 2'd0; end
      XA_FADR1: begin dec.kind = RS_FADR; dec.ch = 2'd1; end
      XA_FCNT1: begin dec.kind = RS_FCNT; dec.ch = 2'd1; end
      XA_FADR2: begin dec.kind = RS_FADR; dec.ch = 2'd2; end
      XA_FCNT2: begin dec.kind = RS_FCNT; dec.ch = 2'd2; end
      default:  dec.kind = RS_NONE;
    endcase
  end
endmodule

// File: rtl/aud_chan_regs.sv
module aud_chan_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_scnt,
  input  logic              wr_fadr,
  input  logic              wr_fcnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  output logic [DATA_W-1:0] scnt_o,
  output logic [DATA_W-1:0] fadr_o,
  output logic [DATA_W-1:0] fcnt_o,
  output logic              lo_clr_o
);
  localparam int unsigned HI_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] scnt_q, scnt_n;
  logic [DATA_W-1:0] fadr_q, fadr_n;
  logic [DATA_W-1:0] fcnt_q, fcnt_n;
  logic              lo_q, lo_n;

  always_comb begin
    scnt_n = scnt_q;
    if (done)    scnt_n[DATA_W-1:CNT_W] = scnt_q[HI_W-1:0];
    if (wr_scnt) scnt_n[CNT_W-1:0]      = wdata[CNT_W-1:0];
    fadr_n = wr_fadr ? wdata : fadr_q;
    fcnt_n = wr_fcnt ? wdata : fcnt_q;
    lo_n   = wr_fcnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      fadr_q <= '0;
      fcnt_q <= '0;
      lo_q   <= 1'b0;
    end else begin
      scnt_q <= scnt_n;
      fadr_q <= fadr_n;
      fcnt_q <= fcnt_n;
      lo_q   <= lo_n;
    end
  end

  assign scnt_o   = scnt_q;
  assign fadr_o   = fadr_q;
  assign fcnt_o   = fcnt_q;
  assign lo_clr_o = lo_q;
endmodule

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl #(
  parameter int unsigned NC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] done,
  input  logic [NC-1:0] en_cur,
  input  logic          en_wr,
  input  logic [NC-1:0] en_new,
  output logic [NC-1:0] pend_o,
  output logic          irq_o
);
  logic [NC-1:0] pend_q, pend_n, fall;

  always_comb begin
    fall   = {NC{en_wr}} & en_cur & ~en_new;
    pend_n = (pend_q | (done & en_cur)) & ~fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;
endmodule

// File: rtl/aud_regbank.sv
module aud_regbank
  import aud_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    chan_done,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     sctl_o,
  output logic [NCH*DW-1:0] scnt_o,
  output logic [NCH*DW-1:0] fadr_o,
  output logic [NCH*DW-1:0] fcnt_o,
  output logic [NCH-1:0]    lo_clr_o,
  output logic              irq_o
);
  logic [DW-1:0] ctrl_q, ctrl_n;
  logic [DW-1:0] sctl_q, sctl_n;
  logic [PW-1:0] page_q, page_n;
  logic [DW-1:0] rdata_q, rdata_n;
  logic [DW-1:0] rd_mux, stat_w;
  logic [NCH-1:0] pend_q;
  logic          en_wr;
  rdec_t         dec;

  logic [DW-1:0] scnt_a [NCH];
  logic [DW-1:0] fadr_a [NCH];
  logic [DW-1:0] fcnt_a [NCH];

  aud_addr_decode u_dec (
    .addr (bus_addr),
    .page (page_q),
    .dec  (dec)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      logic wr_s, wr_a, wr_c;
      assign wr_s = bus_wr && (dec.kind == RS_SCNT) && (dec.ch == CH_W'(g));
      assign wr_a = bus_wr && (dec.kind == RS_FADR) && (dec.ch == CH_W'(g));
      assign wr_c = bus_wr && (dec.kind == RS_FCNT) && (dec.ch == CH_W'(g));

      aud_chan_regs #(.DATA_W(DW), .CNT_W(CW)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_scnt  (wr_s),
        .wr_fadr  (wr_a),
        .wr_fcnt  (wr_c),
        .wdata    (bus_wdata),
        .done     (chan_done[g]),
        .scnt_o   (scnt_a[g]),
        .fadr_o   (fadr_a[g]),
        .fcnt_o   (fcnt_a[g]),
        .lo_clr_o (lo_clr_o[g])
      );

      assign scnt_o[g*DW +: DW] = scnt_a[g];
      assign fadr_o[g*DW +: DW] = fadr_a[g];
      assign fcnt_o[g*DW +: DW] = fcnt_a[g];
    end
  endgenerate

  assign en_wr = bus_wr && (dec.kind == RS_SCTL);

  aud_irq_ctrl #(.NC(NCH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (chan_done),
    .en_cur (sctl_q[EN_LSB +: NCH]),
    .en_wr  (en_wr),
    .en_new (bus_wdata[EN_LSB +: NCH]),
    .pend_o (pend_q),
    .irq_o  (irq_o)
  );

  // Status word: channel 0 flag in the highest of the low bits
  always_comb begin
    stat_w = STAT_FIXED;
    stat_w[DW-1] = irq_o;
    for (int i = 0; i < NCH; i++) stat_w[NCH-1-i] = pend_q[i];
  end

  always_comb begin
    rd_mux = '1;
    unique case (dec.kind)
      RS_CTRL: rd_mux = ctrl_q;
      RS_STAT: rd_mux = stat_w;
      RS_PAGE: rd_mux = DW'(page_q);
      RS_SCTL: rd_mux = sctl_q;
      RS_SCNT: for (int i = 0; i < NCH; i++) if (dec.ch == CH_W'(i)) rd_mux = scnt_a[i];
      RS_FADR: for (int i = 0; i < NCH; i++) if (dec.ch == CH_W'(i)) rd_mux = fadr_a[i];
      RS_FCNT: for (int i = 0; i < NCH; i++) if (dec.ch == CH_W'(i)) rd_mux = fcnt_a[i];
      default: rd_mux = '1;
    endcase
  end

  always_comb begin
    ctrl_n  = ctrl_q;
    sctl_n  = sctl_q;
    page_n  = page_q;
    rdata_n = rdata_q;
    if (bus_wr) begin
      case (dec.kind)
        RS_CTRL: ctrl_n = bus_wdata;
        RS_SCTL: sctl_n = bus_wdata;
        RS_PAGE: page_n = bus_wdata[PW-1:0];
        default: ;
      endcase
    end
    if (bus_rd) rdata_n = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      sctl_q  <= '0;
      page_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_n;
      sctl_q  <= sctl_n;
      page_q  <= page_n;
      rdata_q <= rdata_n;
    end
  end

  assign bus_rdata = rdata_q;
  assign ctrl_o    = ctrl_q;
  assign sctl_o    = sctl_q;
endmodule

// File: rtl/aud_regbank_chk.sv
module aud_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [2:0]  chan_done,
  input logic [31:0] ctrl_o,
  input logic [31:0] sctl_o,
  input logic [95:0] scnt_o,
  input logic [2:0]  lo_clr_o,
  input logic        irq_o,
  input logic [2:0]  pend,
  input logic [3:0]  page
);
  // R2
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 8'h00) |=> bus_rdata == $past(ctrl_o));

  // R6
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h04) |=>
      (bus_rdata[31] == $past(irq_o)) && (bus_rdata[6:5] == 2'b11) &&
      (bus_rdata[2] == $past(pend[0])) && (bus_rdata[1] == $past(pend[1])) &&
      (bus_rdata[0] == $past(pend[2])));

  // R3
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h0C) |=> page == $past(bus_wdata[3:0]));

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~($past(chan_done) & $past(sctl_o[10:8]))) == 3'b000);

  // R8
  en_fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h20) |=>
      (pend & $past(sctl_o[10:8]) & ~$past(bus_wdata[10:8])) == 3'b000);

  // R9
  scnt_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h24 && !chan_done[0]) |=>
      (scnt_o[31:16] == $past(scnt_o[31:16])) && (scnt_o[15:0] == $past(bus_wdata[15:0])));

  // R10
  scnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_done[0] && !(bus_wr && bus_addr == 8'h24)) |=> scnt_o[31:16] == $past(scnt_o[15:0]));

  // R11
  lo_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_clr_o[0] |-> ($past(bus_wr) && $past(bus_addr) == 8'h34 && $past(page) == 4'hC));

  // R5
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h10) |=> ($stable(ctrl_o) && $stable(sctl_o)));
endmodule

bind aud_regbank aud_regbank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .chan_done (chan_done),
  .ctrl_o    (ctrl_o),
  .sctl_o    (sctl_o),
  .scnt_o    (scnt_o),
  .lo_clr_o  (lo_clr_o),
  .irq_o     (irq_o),
  .pend      (pend_q),
  .page      (page_q)
);

// File: tb/aud_regbank_bench.sv
`timescale 1ns/1ps
module aud_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  chan_done = '0;
  logic [31:0] ctrl_o, sctl_o;
  logic [95:0] scnt_o, fadr_o, fcnt_o;
  logic [2:0]  lo_clr_o;
  logic        irq_o;

  always #2 clk = ~clk;

  aud_regbank u_aud_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_done(chan_done), .ctrl_o(ctrl_o), .sctl_o(sctl_o),
    .scnt_o(scnt_o), .fadr_o(fadr_o), .fcnt_o(fcnt_o),
    .lo_clr_o(lo_clr_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;

  // Reference state built from the requirements
  logic [31:0] m_ctrl, m_sctl;
  logic [3:0]  m_page;
  logic [2:0]  m_pend;
  logic [31:0] m_scnt [3];
  logic [31:0] m_fa   [3];
  logic [31:0] m_fc   [3];

  // kinds: 0 none, 1 ctrl, 2 stat, 3 page, 4 sctl, 5 scnt, 6 faddr, 7 fcnt
  function automatic int kind_of(input logic [3:0] p, input logic [7:0] off, output int ch);
    logic [11:0] e;
    e = (off >= 8'h30 && off <= 8'h3F) ? {p, off} : {4'h0, off};
    ch = 0;
    case (e)
      12'h000: return 1;
      12'h004: return 2;
      12'h00C: return 3;
      12'h020: return 4;
      12'h024: begin ch = 0; return 5; end
      12'h028: begin ch = 1; return 5; end
      12'h02C: begin ch = 2; return 5; end
      12'hC30: begin ch = 0; return 6; end
      12'hC34: begin ch = 0; return 7; end
      12'hC38: begin ch = 1; return 6; end
      12'hC3C: begin ch = 1; return 7; end
      12'hD30: begin ch = 2; return 6; end
      12'hD34: begin ch = 2; return 7; end
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] stat_exp();
    return 32'h60 | {(|m_pend), 28'h0, m_pend[0], m_pend[1], m_pend[2]};
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] off);
    int ch, k;
    k = kind_of(m_page, off, ch);
    case (k)
      1: return m_ctrl;
      2: return stat_exp();
      3: return {28'h0, m_page};
      4: return m_sctl;
      5: return m_scnt[ch];
      6: return m_fa[ch];
      7: return m_fc[ch];
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] off);
    int ch, k;
    k = kind_of(m_page, off, ch);
    case (k)
      1, 4: return "R12";
      2: return "R6";
      3: return "R3";
      5: return "R9";
      6, 7: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic void model_step(input logic wr, input logic [7:0] off,
                                     input logic [31:0] d, input logic [2:0] evt);
    int ch, k;
    logic [2:0] en_old;
    en_old = m_sctl[10:8];
    m_pend = m_pend | (evt & en_old);
    for (int i = 0; i < 3; i++) if (evt[i]) m_scnt[i][31:16] = m_scnt[i][15:0];
    if (wr) begin
      k = kind_of(m_page, off, ch);
      case (k)
        1: m_ctrl = d;
        3: m_page = d[3:0];
        4: begin m_pend = m_pend & ~(en_old & ~d[10:8]); m_sctl = d; end
        5: m_scnt[ch][15:0] = d[15:0];
        6: m_fa[ch] = d;
        7: m_fc[ch] = d;
        default: ;
      endcase
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d, input logic [2:0] evt = 3'b000);
    int ch, k;
    logic [2:0] lo_exp;
    k = kind_of(m_page, off, ch);
    lo_exp = (k == 7) ? 3'(1 << ch) : 3'b000;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = off; bus_wdata = d; chan_done = evt;
    model_step(1'b1, off, d, evt);
    @(negedge clk);
    bus_wr = 1'b0; chan_done = '0;
    check("R11 leftover clear", {29'h0, lo_clr_o}, {29'h0, lo_exp});
  endtask

  task automatic pulse(input logic [2:0] evt);
    @(negedge clk);
    chan_done = evt;
    model_step(1'b0, 8'h00, 32'h0, evt);
    @(negedge clk);
    chan_done = '0;
  endtask

  task automatic rd(input logic [7:0] off, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = off;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp_read(off));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    m_ctrl = 32'h1; m_sctl = '0; m_page = '0; m_pend = '0;
    for (int i = 0; i < 3; i++) begin m_scnt[i] = '0; m_fa[i] = '0; m_fc[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 registered read
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    check("R1 lo_clr", {29'h0, lo_clr_o}, 32'h0);
    check("R1 ctrl_o", ctrl_o, 32'h1);
    rd(8'h00, "R1 R2 ctrl");
    rd(8'h04, "R1 status");
    rd(8'h0C, "R1 page");
    rd(8'h20, "R1 sctl");
    rd(8'h24, "R1 scnt");

    // Sweep every page and offset
    for (int p = 0; p < 16; p++) begin
      wr(8'h0C, {28'hFEDCBA9, 4'(p)});
      rd(8'h0C, "R3 page low bits");
      for (int o = 0; o < 256; o += 4) begin
        if (o != 'h0C) wr(8'(o), {4'(p), 4'hA, 8'(o), ~8'(o), 4'h3, 4'(p)});
      end
      for (int o = 0; o < 256; o++) begin
        if ((o % 4) == 0 || o == 'h31 || o == 'h06) rd(8'(o), tag_of(8'(o)));
      end
    end
    check("R12 ctrl_o", ctrl_o, m_ctrl);
    check("R12 sctl_o", sctl_o, m_sctl);
    for (int i = 0; i < 3; i++) begin
      check("R4 fadr_o", fadr_o[i*32 +: 32], m_fa[i]);
      check("R4 fcnt_o", fcnt_o[i*32 +: 32], m_fc[i]);
      check("R9 scnt_o", scnt_o[i*32 +: 32], m_scnt[i]);
    end

    // Interrupt enable combinations
    for (int m = 0; m < 8; m++) begin
      wr(8'h20, 32'h700);
      wr(8'h20, 32'h0);
      rd(8'h04, "R8 cleared by falling enables");
      wr(8'h20, {21'h0, 3'(m), 8'h0});
      pulse(3'b111);
      check("R6 irq level", {31'h0, irq_o}, {31'h0, (m != 0)});
      rd(8'h04, "R7 pending by enable");
      for (int i = 0; i < 3; i++) begin
        if (m[i]) begin
          wr(8'h20, m_sctl & ~(32'h100 << i));
          rd(8'h04, "R8 single falling enable");
        end
      end
      check("R6 irq after clears", {31'h0, irq_o}, 32'h0);
    end

    // Status write ignored, coincident cases
    wr(8'h20, 32'h700);
    pulse(3'b101);
    wr(8'h04, 32'h0);
    rd(8'h04, "R8 status write ignored");
    check("R6 irq set", {31'h0, irq_o}, 32'h1);
    wr(8'h20, 32'h0, 3'b111);
    rd(8'h04, "R8 clear wins over event");
    check("R8 irq low", {31'h0, irq_o}, 32'h0);
    wr(8'h20, 32'h700, 3'b111);
    rd(8'h04, "R7 enable raised with event");

    // Sample-count reload
    for (int i = 0; i < 3; i++) begin
      wr(8'(8'h24 + 4 * i), 32'hFFFF_0000 | (32'h1111 * (i + 1)));
      rd(8'(8'h24 + 4 * i), "R9 low half only");
      pulse(3'(1 << i));
      rd(8'(8'h24 + 4 * i), "R10 reload upper");
    end
    rd(8'h04, "R7 pending after reload pulses");

    summary();
    $finish;
  end
endmodule